// File: doc/BRIEF.md
# Field-Masked DSP Control Register

This block holds a 32-bit control and status word for a DSP datapath. The word is divided into six fields: a 6-bit extract position, a 6-bit shift count, a carry bit, an extract-fail bit, an 8-bit overflow flag byte and an 8-bit condition-code byte. Software-visible access goes through a 6-bit field mask and never through byte or word enables. On a write, only the fields picked by the write mask take their bits from the source word, and every other field keeps its value. On a read, only the fields picked by the read mask are returned, and every other bit reads as zero.

Neighbouring arithmetic units also update the register through side ports. They can set overflow bits, which stay set until a write clears them. They can load a new position value and a new extract-fail value. When a masked write and a side update target the same field in the same cycle, the masked write takes priority. Overflow bits raised in that cycle are still ORed in after the write.

Top module: `dsp_field_reg`

## Requirements
- R1: After reset every bit of the register is zero.
- R2: Field mask bits map as follows: bit 0 to position bits 5:0, bit 1 to shift count bits 12:7, bit 2 to carry bit 13, bit 3 to overflow byte bits 23:16, bit 4 to condition byte bits 31:24, and bit 5 to extract-fail bit 14.
- R3: A strobed write replaces exactly the selected fields with the source bits on the next clock edge and preserves all unselected fields.
- R4: Read data equals the register ANDed with the fields picked by the read mask, combinationally in the same cycle. All other bits are zero.
- R5: Bits 6 and 15 always read as zero and cannot be written.
- R6: A position side update loads the position field on the next edge, unless a write selecting the position field occurs in the same cycle, in which case the write wins.
- R7: An extract-fail side update loads bit 14 on the next edge, unless a write selecting mask bit 5 occurs in the same cycle, in which case the write wins.
- R8: Overflow set bits are ORed into bits 23:16 after any write in the same cycle, so they are set on the next edge even when the write clears the byte.
- R9: A write with the strobe low, or with an all-zero write mask, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_mask | input | 6 | Fields a write may change |
| wr_data | input | 32 | Source word for writes |
| rd_mask | input | 6 | Fields returned on read |
| rd_data | output | 32 | Masked read data |
| ovf_set | input | 8 | Sticky overflow bits to set |
| pos_upd | input | 1 | Position side update strobe |
| pos_val | input | 6 | New position value |
| fail_upd | input | 1 | Extract-fail side update strobe |
| fail_val | input | 1 | New extract-fail value |

## Verification
The assertions check four things on every cycle:
- The reserved bits stay zero.
- The condition byte holds still unless a write selects it.
- Raised overflow bits are present on the next edge.
- A position update takes effect whenever no competing write selects that field.

Only the bench scenarios can show the rest. This covers the exact merge of mixed masks, reads returning only the picked fields, and the write-over-side-port priority for the fail bit. It also covers a write that clears the overflow byte while overflow bits are raised in the same cycle. A behavioural model tracks all of these across a long pseudo-random sequence.

// File: rtl/dsp_field_reg.sv
module dsp_field_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  wr_mask,
  input  logic [31:0] wr_data,
  input  logic [5:0]  rd_mask,
  output logic [31:0] rd_data,
  input  logic [7:0]  ovf_set,
  input  logic        pos_upd,
  input  logic [5:0]  pos_val,
  input  logic        fail_upd,
  input  logic        fail_val
);

  localparam int W = 32;

  function automatic logic [W-1:0] field_bits(input logic [5:0] m);
    field_bits = {{8{m[4]}}, {8{m[3]}}, 1'b0, m[5], m[2], {6{m[1]}}, 1'b0, {6{m[0]}}};
  endfunction

  logic [W-1:0] ctl_q, ctl_d, wsel;

  assign wsel    = wr_en ? field_bits(wr_mask) : '0;
  assign rd_data = ctl_q & field_bits(rd_mask);

  always_comb begin
    ctl_d = ctl_q;
    if (pos_upd)  ctl_d[5:0] = pos_val;
    if (fail_upd) ctl_d[14]  = fail_val;
    ctl_d = (ctl_d & ~wsel) | (wr_data & wsel);
    ctl_d[23:16] = ctl_d[23:16] | ovf_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // R5
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[6] == 1'b0) && (ctl_q[15] == 1'b0));

  // R3
  a_r3_cc_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_mask[4]) |=> $stable(ctl_q[31:24]));

  // R8
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set != 8'h00) |=> ((rd_data[23:16] & $past(ovf_set)) == $past(ovf_set)) || !rd_mask[3]);

  // R6
  a_r6_pos_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_upd && !(wr_en && wr_mask[0])) |=> (ctl_q[5:0] == $past(pos_val)));

endmodule

// File: tb/sim_dsp_field_reg.sv
`timescale 1ns/1ps
module sim_dsp_field_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] rd_mask = '0;
  logic [31:0] rd_data;
  logic [7:0] ovf_set = '0;
  logic pos_upd = 1'b0;
  logic [5:0] pos_val = '0;
  logic fail_upd = 1'b0;
  logic fail_val = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;
  logic [31:0] lfsr = 32'h1357_9BDF;

  always #2 clk = ~clk;

  dsp_field_reg u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_mask(rd_mask), .rd_data(rd_data), .ovf_set(ovf_set),
    .pos_upd(pos_upd), .pos_val(pos_val), .fail_upd(fail_upd), .fail_val(fail_val));

  function automatic logic [31:0] pick(input logic [5:0] m);
    logic [31:0] r = '0;
    if (m[0]) r = r | 32'h0000_003F;
    if (m[1]) r = r | 32'h0000_1F80;
    if (m[2]) r = r | 32'h0000_2000;
    if (m[5]) r = r | 32'h0000_4000;
    if (m[3]) r = r | 32'h00FF_0000;
    if (m[4]) r = r | 32'hFF00_0000;
    return r;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [5:0] wm, input logic [31:0] wd,
                      input logic [5:0] rm, input logic [7:0] ov, input bit pu,
                      input logic [5:0] pv, input bit fu, input bit fv, input string tag);
    logic [31:0] nm;
    @(negedge clk);
    wr_en = we; wr_mask = wm; wr_data = wd; rd_mask = rm;
    ovf_set = ov; pos_upd = pu; pos_val = pv; fail_upd = fu; fail_val = fv;
    #1;
    check(rd_data, model & pick(rm), tag);
    @(posedge clk);
    nm = model;
    if (pu) nm[5:0] = pv;
    if (fu) nm[14] = fv;
    if (we) nm = (nm & ~pick(wm)) | (wd & pick(wm));
    nm[23:16] = nm[23:16] | ov;
    model = nm;
  endtask

  initial begin
    #400000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_mask = 6'h3F;
    #1 check(rd_data, 32'h0, "R1 reset state");
    step(1, 6'h3F, 32'hFFFF_FFFF, 6'h3F, 0, 0, 0, 0, 0, "R3 full write");
    step(0, 0, 0, 6'h3F, 0, 0, 0, 0, 0, "R5 reserved zero after all-ones");
    check(rd_data & 32'h0000_8040, 32'h0, "R5 bits 6 and 15");
    step(0, 0, 0, 6'h01, 0, 0, 0, 0, 0, "R2 position field read");
    step(0, 0, 0, 6'h02, 0, 0, 0, 0, 0, "R2 shift field read");
    step(0, 0, 0, 6'h04, 0, 0, 0, 0, 0, "R2 carry read");
    step(0, 0, 0, 6'h08, 0, 0, 0, 0, 0, "R2 overflow byte read");
    step(0, 0, 0, 6'h10, 0, 0, 0, 0, 0, "R2 condition byte read");
    step(0, 0, 0, 6'h20, 0, 0, 0, 0, 0, "R2 fail bit read");
    step(1, 6'h05, 32'h0, 6'h3F, 0, 0, 0, 0, 0, "R3 partial clear");
    step(0, 6'h3F, 32'h0, 6'h3F, 0, 0, 0, 0, 0, "R3 merge preserved others");
    step(1, 6'h00, 32'h0, 6'h3F, 0, 0, 0, 0, 0, "R9 strobe low ignored");
    step(0, 0, 0, 6'h3F, 0, 0, 0, 0, 0, "R9 zero mask ignored");
    step(1, 6'h01, 32'h0000_0011, 6'h3F, 0, 1, 6'h2A, 0, 0, "R9 before conflict");
    step(0, 0, 0, 6'h01, 0, 1, 6'h07, 0, 0, "R6 write beat position update");
    step(1, 6'h20, 32'h0, 6'h01, 0, 1, 6'h07, 1, 1, "R6 side position loaded");
    step(0, 0, 0, 6'h20, 0, 0, 0, 1, 1, "R7 write beat fail update");
    step(1, 6'h08, 32'h0, 6'h20, 8'h81, 0, 0, 0, 0, "R7 side fail loaded");
    step(0, 0, 0, 6'h08, 0, 0, 0, 0, 0, "R8 overflow ORed after clear");
    step(0, 0, 0, 6'h08, 8'h10, 0, 0, 0, 0, "R8 overflow sticky");
    step(0, 0, 0, 6'h08, 0, 0, 0, 0, 0, "R8 overflow accumulated");
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[6:1], {lfsr[15:0], lfsr[31:16]} ^ 32'hA5C3_5A3C, lfsr[12:7],
           (lfsr[13] & lfsr[14]) ? lfsr[22:15] : 8'h00, lfsr[23], lfsr[29:24],
           lfsr[30], lfsr[31], "R3 random merge and R4 read");
    end
    step(0, 0, 0, 6'h3F, 0, 0, 0, 0, 0, "R4 final read");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule